// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of a three-wire configuration port. An external host holds an active-low frame strobe, toggles a serial clock and shares one data line with the block. Inside each frame the host first sends a header: a direction flag, a register address and padding. A write frame then carries a data byte. In a read frame the block takes over the data line and shifts out the addressed register. The block holds eight 8-bit registers. One is a channel multiplexer control register, three are per-colour offset registers, three are per-colour gain registers and one is spare. The seven configuration registers drive parallel outputs into the rest of the chip.

The pins are asynchronous to the system clock. They pass through two synchronizing flops, and all edges are detected in the system clock domain. The system clock must run at least eight times faster than the serial clock, so that read data is on the line well before the host samples it. A write changes the register file only at the end of its frame, when the strobe rises. The data line output enable is raised only for the data phase of a read.

Top module: `ser_reg_port`

## Requirements
- R1: After reset all eight registers read 0, and `sdata_oe_o` is low.
- R2: A write frame is 16 bits, sampled on rising serial clock edges. Bit 0 is the direction flag and is 0 for a write. Bits 1..3 are the address, MSB first. Bits 4..7 are padding and are ignored. Bits 8..15 are the data byte, MSB first.
- R3: Write data reaches the addressed register only after the strobe rises. While the strobe stays low after the 16th bit, every register keeps its old value.
- R4: If the strobe rises before 16 rising edges have arrived, the frame is discarded and no register changes.
- R5: Rising serial clock edges after the 16th in a frame are ignored. The committed byte comes from bits 8..15.
- R6: A read frame has flag 1 in bit 0. From the 8th falling serial clock edge on, the block drives the addressed register MSB first and advances one bit per falling edge. Each bit is valid within four system clocks of its falling edge.
- R7: `sdata_oe_o` is high only in a read frame, from the 8th falling edge until the strobe rises. It is low at all other times.
- R8: A read frame changes no register.
- R9: Register map: address 0 drives `ctrl_o`. Addresses 1..3 drive `offset_o` bytes 0..2 (address 1 drives bits 7:0). Addresses 4..6 drive `gain_o` bytes 0..2. Address 7 is reachable only through reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| frame_ni | input | 1 | Active-low frame strobe |
| sdata_i | input | 1 | Data line, input side |
| sdata_o | output | 1 | Data line, output side |
| sdata_oe_o | output | 1 | Data line output enable |
| ctrl_o | output | 8 | Channel multiplexer control register |
| offset_o | output | 24 | Three per-colour offset registers |
| gain_o | output | 24 | Three per-colour gain registers |

## Verification
The hardest situation to reach is a write that has all 16 bits but is not yet committed. The host has to keep the strobe low for a long time after the last bit, and every system clock in that window must show the old register contents. The bench holds the strobe low for 20 system clocks after each full write, with the per-clock comparison still running. It also ends frames early, at 10 and 15 bits, and sends 20-bit frames with junk in the extra bits. Each of these is followed by a read, so the result is seen through the port itself.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_OFS0  = 1;
  localparam int unsigned ADDR_GAIN0 = 4;
  localparam int unsigned NUM_COLOUR = 3;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] st [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st[s] <= RST;
      prev <= RST;
    end else begin
      st[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
      prev <= st[STAGES-1];
    end
  end

  assign q_o    = st[STAGES-1];
  assign rise_o = st[STAGES-1] & ~prev;
  assign fall_o = ~st[STAGES-1] & prev;
endmodule

// File: rtl/ser_frame_dec.sv
module ser_frame_dec #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3,
  localparam int unsigned FB = 2 * DW,
  localparam int unsigned CW = $clog2(FB + 1),
  localparam int unsigned FW = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_lvl_i,
  input  logic          frame_fall_i,
  input  logic          frame_rise_i,
  input  logic          sclk_rise_i,
  input  logic          sclk_fall_i,
  input  logic          sdata_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdo_o,
  output logic          oe_o,
  output logic [CW-1:0] bit_cnt_o
);
  logic [FB-1:0] sh;
  logic [CW-1:0] cnt;
  logic [FW-1:0] fcnt;
  logic [DW-1:0] osh;
  logic          oe_q;
  logic          active;

  assign active = ~frame_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh   <= '0;
      cnt  <= '0;
      fcnt <= '0;
      osh  <= '0;
      oe_q <= 1'b0;
    end else if (frame_fall_i) begin
      sh   <= '0;
      cnt  <= '0;
      fcnt <= '0;
      oe_q <= 1'b0;
    end else if (frame_rise_i) begin
      oe_q <= 1'b0;
    end else if (active) begin
      if (sclk_rise_i && cnt != CW'(FB)) begin
        sh  <= {sh[FB-2:0], sdata_i};
        cnt <= cnt + 1'b1;
      end
      if (sclk_fall_i) begin
        if (fcnt != FW'(DW)) fcnt <= fcnt + 1'b1;
        // header complete: direction flag sits at sh[DW-1]
        if (fcnt == FW'(DW - 1) && cnt == CW'(DW) && sh[DW-1]) begin
          oe_q <= 1'b1;
          osh  <= rd_data_i;
        end else if (oe_q) begin
          osh <= {osh[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign rd_addr_o = sh[DW-2 -: AW];
  assign wr_en_o   = frame_rise_i && cnt == CW'(FB) && !sh[FB-1];
  assign wr_addr_o = sh[FB-2 -: AW];
  assign wr_data_o = sh[DW-1:0];
  assign sdo_o     = osh[DW-1];
  assign oe_o      = oe_q;
  assign bit_cnt_o = cnt;
endmodule

// File: rtl/ser_regs.sv
module ser_regs #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3,
  localparam int unsigned NREG = 1 << AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [AW-1:0]      raddr_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NREG; k++) mem[k] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_o[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import ser_reg_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   frame_ni,
  input  logic                   sdata_i,
  output logic                   sdata_o,
  output logic                   sdata_oe_o,
  output logic [DW-1:0]          ctrl_o,
  output logic [NUM_COLOUR*DW-1:0] offset_o,
  output logic [NUM_COLOUR*DW-1:0] gain_o
);
  localparam int unsigned NREG = 1 << AW;
  localparam int unsigned CW   = $clog2(2 * DW + 1);

  logic [2:0] pin_q, pin_rise, pin_fall;
  logic          sclk_rise, sclk_fall, frame_lvl, frame_rise, frame_fall, sdata_s;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en;
  logic [CW-1:0] bit_cnt;
  logic [NREG*DW-1:0] regs_flat;

  // bit 0 sclk, bit 1 strobe, bit 2 data
  ser_sync #(.N(3), .STAGES(2), .RST(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdata_i, frame_ni, sclk_i}),
    .q_o    (pin_q),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign sclk_rise  = pin_rise[0];
  assign sclk_fall  = pin_fall[0];
  assign frame_lvl  = pin_q[1];
  assign frame_rise = pin_rise[1];
  assign frame_fall = pin_fall[1];
  assign sdata_s    = pin_q[2];

  ser_frame_dec #(.DW(DW), .AW(AW)) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_lvl_i  (frame_lvl),
    .frame_fall_i (frame_fall),
    .frame_rise_i (frame_rise),
    .sclk_rise_i  (sclk_rise),
    .sclk_fall_i  (sclk_fall),
    .sdata_i      (sdata_s),
    .rd_data_i    (rd_data),
    .rd_addr_o    (rd_addr),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .sdo_o        (sdata_o),
    .oe_o         (sdata_oe_o),
    .bit_cnt_o    (bit_cnt)
  );

  ser_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .raddr_i (rd_addr),
    .rdata_o (rd_data),
    .regs_o  (regs_flat)
  );

  assign ctrl_o   = regs_flat[ADDR_CTRL*DW +: DW];
  assign offset_o = regs_flat[ADDR_OFS0*DW +: NUM_COLOUR*DW];
  assign gain_o   = regs_flat[ADDR_GAIN0*DW +: NUM_COLOUR*DW];
endmodule

// File: rtl/ser_reg_port_chk.sv
module ser_reg_port_chk #(
  parameter int unsigned W  = 64,
  parameter int unsigned CW = 5,
  parameter int unsigned FB = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_rise,
  input logic          sclk_fall,
  input logic          oe,
  input logic          sdo,
  input logic [W-1:0]  cfg,
  input logic [CW-1:0] bit_cnt
);
  p_oe_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_rise |=> !oe);

  p_commit_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg) |-> $past(frame_rise));

  p_oe_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe) |-> $past(sclk_fall));

  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe && $past(oe) && !$past(sclk_fall)) |-> $stable(sdo));

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CW'(FB));
endmodule

bind ser_reg_port ser_reg_port_chk #(.W(NREG*DW), .CW(CW), .FB(2*DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_rise (frame_rise),
  .sclk_fall  (sclk_fall),
  .oe         (sdata_oe_o),
  .sdo        (sdata_o),
  .cfg        (regs_flat),
  .bit_cnt    (bit_cnt)
);

// File: tb/sim_ser_reg_port.sv
module sim_ser_reg_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, frame_n = 1'b1, sdi = 1'b0;
  logic sdo, oe;
  logic [7:0]  ctrl;
  logic [23:0] ofs, gain;

  int errors = 0, checks = 0;
  int mdl [8];
  bit busy = 1'b0, settle = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_reg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .frame_ni(frame_n),
    .sdata_i(sdi), .sdata_o(sdo), .sdata_oe_o(oe),
    .ctrl_o(ctrl), .offset_o(ofs), .gain_o(gain)
  );

  function automatic int get_reg(int a);
    case (a)
      0: return int'(ctrl);
      1, 2, 3: return int'(ofs[(a-1)*8 +: 8]);
      4, 5, 6: return int'(gain[(a-4)*8 +: 8]);
      default: return -1;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model (R3, R8, R9, R7 idle)
  always @(negedge clk) begin
    if (rst_n && !settle) begin
      for (int a = 0; a < 7; a++)
        chk(get_reg(a) == mdl[a], $sformatf("R3/R8/R9 per-clock reg %0d", a), get_reg(a), mdl[a]);
      if (!busy) chk(oe == 1'b0, "R7 idle oe", int'(oe), 0);
    end
  end

  task automatic frame(bit rd, int a, int d, int pad, int nbits, int hold);
    logic [15:0] w;
    w = {rd, a[2:0], pad[3:0], d[7:0]};
    busy = 1'b1;
    frame_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (rd && i >= 8) sdi = 1'b0;
      else sdi = (i < 16) ? w[15-i] : ~w[0];
      if (rd && i < 8) chk(oe == 1'b0, "R7 oe before 8th fall", int'(oe), 0);
      if (rd && i >= 8 && i < 16) begin
        chk(oe == 1'b1, "R7 oe in read data phase", int'(oe), 1);
        chk(sdo == w[15-i], $sformatf("R6 read bit %0d addr %0d", i, a), int'(sdo), int'(w[15-i]));
      end
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (hold) @(negedge clk);
    if (!rd && nbits >= 16 && a < 7)
      chk(get_reg(a) == mdl[a], "R3 no commit while strobe low", get_reg(a), mdl[a]);
    frame_n = 1'b1;
    settle = 1'b1;
    repeat (6) @(negedge clk);
    if (!rd && nbits >= 16) mdl[a] = d & 8'hff;
    @(negedge clk);
    settle = 1'b0;
    chk(oe == 1'b0, "R7 oe after strobe rise", int'(oe), 0);
    busy = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(int a, int d, int pad);
    frame(1'b0, a, d, pad, 16, 20);
  endtask

  task automatic rd(int a, int pad);
    frame(1'b1, a, mdl[a], pad, 16, 4);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) mdl[k] = 0;
    settle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    settle = 1'b0;
    // R1
    for (int a = 0; a < 7; a++) chk(get_reg(a) == 0, "R1 reset value", get_reg(a), 0);
    chk(oe == 1'b0, "R1 reset oe", int'(oe), 0);
    rd(7, 0);

    // R2, R9: every address, with padding patterns
    for (int a = 0; a < 8; a++) wr(a, (a * 37 + 11) & 255, (a * 5) & 15);
    chk(ctrl == 8'd11, "R9 ctrl map", int'(ctrl), 11);
    chk(ofs == {8'd122, 8'd85, 8'd48}, "R9 offset map", int'(ofs), 24'h7a5530);
    chk(gain == {8'd233, 8'd196, 8'd159}, "R9 gain map", int'(gain), 24'he9c49f);
    for (int a = 0; a < 8; a++) rd(a, 15 - a);

    // R2 padding all ones ignored
    wr(3, 8'h5a, 15);
    chk(get_reg(3) == 8'h5a, "R2 pad ignored", get_reg(3), 8'h5a);

    // R4 short frames
    frame(1'b0, 2, 8'h00, 0, 10, 4);
    frame(1'b0, 2, 8'hff, 0, 15, 4);
    chk(get_reg(2) == mdl[2], "R4 short frame discarded", get_reg(2), mdl[2]);
    rd(2, 0);

    // R5 extra clocks
    frame(1'b0, 5, 8'hc3, 0, 20, 4);
    chk(get_reg(5) == 8'hc3, "R5 extra pulses ignored", get_reg(5), 8'hc3);
    rd(5, 0);

    // R8 read leaves registers unchanged
    rd(0, 9);
    chk(get_reg(0) == mdl[0], "R8 read no side effect", get_reg(0), mdl[0]);
    wr(7, 8'h81, 6);
    rd(7, 3);
    wr(0, 8'hff, 0);
    rd(0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule